// File: doc/BRIEF.md
# Dual-Select Out-of-Order Issue Queue

This block is a six-slot holding queue that sits between instruction dispatch and two identical integer execution pipes. Dispatch writes one instruction per cycle carrying an opcode, a destination tag, an age stamp and two source operands. Each source arrives either as a finished value or as the tag of the instruction that will produce it. The queue watches a shared result broadcast bus. Any waiting source whose tag matches a broadcast copies the value and becomes ready.

In every cycle the queue offers up to two instructions whose sources are both ready, one on each issue port. Selection is by age, not by position or arrival slot, so a young instruction with its data in hand overtakes an old one that is still waiting. A flush request removes every instruction younger than a given age stamp.

Ages are compared as unsigned numbers. The dispatch side gives every live instruction a distinct age and never lets the stamps wrap while instructions are in the queue. A smaller age means an older instruction.

Top module: `rs_dual_select`

## Requirements
- R1: After reset the queue is empty, `dispReady` is 1 and neither issue port is valid.
- R2: An instruction is accepted on a clock edge where `dispValid` and `dispReady` are both 1. If both of its sources were marked ready at dispatch, it may issue from the next cycle on.
- R3: When `bcastValid` is 1, every held source that is waiting on `bcastTag` copies `bcastVal` at the clock edge. Its instruction may issue from the next cycle with that value on the operand output.
- R4: A source dispatched as waiting on a tag that is broadcast in the same cycle as the dispatch captures the broadcast value, so no wakeup is lost.
- R5: Port 0 carries the eligible entry with the smallest age. Port 1 carries the eligible entry with the next smallest age. Port 1 is never valid while port 0 is invalid. Issue outputs depend combinationally on the held state.
- R6: A younger instruction with both sources ready issues while an older instruction in the queue is still waiting on an operand.
- R7: `dispReady` is 0 exactly when all six slots are occupied, and a dispatch offered then is dropped. A slot freed by an issue becomes available from the following cycle.
- R8: In a cycle with `flushValid` at 1, entries whose age is greater than `flushAge` are removed at the clock edge and are not presented on either issue port in that cycle. A dispatch in the same cycle with an age greater than `flushAge` is dropped.
- R9: Every accepted instruction is issued at most once and leaves the queue at the edge that ends its issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dispValid | input | 1 | Dispatch request |
| dispReady | output | 1 | At least one free slot |
| dispOp | input | 4 | Opcode of the dispatched instruction |
| dispDst | input | 5 | Destination tag |
| dispAge | input | 8 | Age stamp (smaller is older) |
| dispARdy | input | 1 | Source A holds a value (1) or waits on a tag (0) |
| dispATag | input | 5 | Producer tag of source A |
| dispAVal | input | 16 | Value of source A |
| dispBRdy | input | 1 | Source B holds a value (1) or waits on a tag (0) |
| dispBTag | input | 5 | Producer tag of source B |
| dispBVal | input | 16 | Value of source B |
| bcastValid | input | 1 | Result broadcast valid |
| bcastTag | input | 5 | Tag of the broadcast result |
| bcastVal | input | 16 | Broadcast result value |
| flushValid | input | 1 | Remove younger entries |
| flushAge | input | 8 | Entries older than or equal to this age survive |
| iss0Valid | output | 1 | Issue port 0 valid |
| iss0Op | output | 4 | Port 0 opcode |
| iss0Dst | output | 5 | Port 0 destination tag |
| iss0Age | output | 8 | Port 0 age stamp |
| iss0SrcA | output | 16 | Port 0 operand A |
| iss0SrcB | output | 16 | Port 0 operand B |
| iss1Valid | output | 1 | Issue port 1 valid |
| iss1Op | output | 4 | Port 1 opcode |
| iss1Dst | output | 5 | Port 1 destination tag |
| iss1Age | output | 8 | Port 1 age stamp |
| iss1SrcA | output | 16 | Port 1 operand A |
| iss1SrcB | output | 16 | Port 1 operand B |

## Verification
The age-ordering and flush properties assume that the dispatch side stamps each live instruction with a distinct, non-wrapping age. The bench therefore hands out ages from a rising counter. Between random phases it clears the queue with a flush at age zero before restarting the counter at one. Broadcast tags are drawn from a small pool, so wakeups that hit several entries at once, and wakeups that hit nothing, both occur often. Flushes use ages a few steps behind the counter, so each flush splits the live entries into survivors and victims.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_DEPTH = 6;
  parameter int RS_IDX_W = $clog2(RS_DEPTH);

  // strobes from control to datapath
  typedef struct packed {
    logic [RS_DEPTH-1:0] allocMask;
    logic                pick0Vld;
    logic [RS_IDX_W-1:0] pick0;
    logic                pick1Vld;
    logic [RS_IDX_W-1:0] pick1;
  } rsStrobe_t;
endpackage

// File: rtl/rs_data.sv
module rs_data
  import rs_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 5,
  parameter int AGE_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strobe,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [TAG_W-1:0]  dispDst,
  input  logic [AGE_W-1:0]  dispAge,
  input  logic              dispARdy,
  input  logic [TAG_W-1:0]  dispATag,
  input  logic [DATA_W-1:0] dispAVal,
  input  logic              dispBRdy,
  input  logic [TAG_W-1:0]  dispBTag,
  input  logic [DATA_W-1:0] dispBVal,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastVal,
  output logic [RS_DEPTH-1:0] entReady,
  output logic [AGE_W-1:0]  entAge [RS_DEPTH],
  output logic [OP_W-1:0]   iss0Op,
  output logic [TAG_W-1:0]  iss0Dst,
  output logic [AGE_W-1:0]  iss0Age,
  output logic [DATA_W-1:0] iss0SrcA,
  output logic [DATA_W-1:0] iss0SrcB,
  output logic [OP_W-1:0]   iss1Op,
  output logic [TAG_W-1:0]  iss1Dst,
  output logic [AGE_W-1:0]  iss1Age,
  output logic [DATA_W-1:0] iss1SrcA,
  output logic [DATA_W-1:0] iss1SrcB
);
  logic [OP_W-1:0]   opQ   [RS_DEPTH];
  logic [TAG_W-1:0]  dstQ  [RS_DEPTH];
  logic [AGE_W-1:0]  ageQ  [RS_DEPTH];
  logic [RS_DEPTH-1:0] aRdyQ, bRdyQ;
  logic [TAG_W-1:0]  aTagQ [RS_DEPTH];
  logic [TAG_W-1:0]  bTagQ [RS_DEPTH];
  logic [DATA_W-1:0] aValQ [RS_DEPTH];
  logic [DATA_W-1:0] bValQ [RS_DEPTH];

  // a source dispatched as waiting may be satisfied by this cycle's broadcast
  logic dispAHit, dispBHit;
  assign dispAHit = bcastValid && !dispARdy && (dispATag == bcastTag);
  assign dispBHit = bcastValid && !dispBRdy && (dispBTag == bcastTag);

  for (genvar e = 0; e < RS_DEPTH; e++) begin : g_ent
    logic aHit, bHit;
    assign aHit = bcastValid && !aRdyQ[e] && (aTagQ[e] == bcastTag);
    assign bHit = bcastValid && !bRdyQ[e] && (bTagQ[e] == bcastTag);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opQ[e]   <= '0;
        dstQ[e]  <= '0;
        ageQ[e]  <= '0;
        aRdyQ[e] <= 1'b0;
        bRdyQ[e] <= 1'b0;
        aTagQ[e] <= '0;
        bTagQ[e] <= '0;
        aValQ[e] <= '0;
        bValQ[e] <= '0;
      end else if (strobe.allocMask[e]) begin
        opQ[e]   <= dispOp;
        dstQ[e]  <= dispDst;
        ageQ[e]  <= dispAge;
        aTagQ[e] <= dispATag;
        bTagQ[e] <= dispBTag;
        aRdyQ[e] <= dispARdy | dispAHit;
        bRdyQ[e] <= dispBRdy | dispBHit;
        aValQ[e] <= dispARdy ? dispAVal : bcastVal;
        bValQ[e] <= dispBRdy ? dispBVal : bcastVal;
      end else begin
        if (aHit) begin
          aRdyQ[e] <= 1'b1;
          aValQ[e] <= bcastVal;
        end
        if (bHit) begin
          bRdyQ[e] <= 1'b1;
          bValQ[e] <= bcastVal;
        end
      end
    end

    assign entReady[e] = aRdyQ[e] & bRdyQ[e];
    assign entAge[e]   = ageQ[e];
  end

  assign iss0Op   = opQ[strobe.pick0];
  assign iss0Dst  = dstQ[strobe.pick0];
  assign iss0Age  = ageQ[strobe.pick0];
  assign iss0SrcA = aValQ[strobe.pick0];
  assign iss0SrcB = bValQ[strobe.pick0];
  assign iss1Op   = opQ[strobe.pick1];
  assign iss1Dst  = dstQ[strobe.pick1];
  assign iss1Age  = ageQ[strobe.pick1];
  assign iss1SrcA = aValQ[strobe.pick1];
  assign iss1SrcB = bValQ[strobe.pick1];
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int AGE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dispValid,
  input  logic [AGE_W-1:0]    dispAge,
  input  logic                flushValid,
  input  logic [AGE_W-1:0]    flushAge,
  input  logic [RS_DEPTH-1:0] entReady,
  input  logic [AGE_W-1:0]    entAge [RS_DEPTH],
  output logic                dispReady,
  output rsStrobe_t           strobe,
  output logic [RS_DEPTH-1:0] entValid
);
  logic [RS_DEPTH-1:0] validQ, killMask, eligMask, issueMask;
  logic                dispDropped;

  assign entValid    = validQ;
  assign dispReady   = ~&validQ;
  assign dispDropped = flushValid && (dispAge > flushAge);

  always_comb begin
    logic [AGE_W-1:0] best0, best1;
    logic             found;
    strobe    = '0;
    best0     = '0;
    best1     = '0;
    found     = 1'b0;
    issueMask = '0;
    for (int e = 0; e < RS_DEPTH; e++) begin
      killMask[e] = flushValid && validQ[e] && (entAge[e] > flushAge);
    end
    eligMask = validQ & entReady & ~killMask;
    // oldest eligible entry
    for (int e = 0; e < RS_DEPTH; e++) begin
      if (eligMask[e] && (!strobe.pick0Vld || entAge[e] < best0)) begin
        strobe.pick0Vld = 1'b1;
        strobe.pick0    = RS_IDX_W'(e);
        best0           = entAge[e];
      end
    end
    // oldest of the rest
    for (int e = 0; e < RS_DEPTH; e++) begin
      if (eligMask[e] && (RS_IDX_W'(e) != strobe.pick0) &&
          (!strobe.pick1Vld || entAge[e] < best1)) begin
        strobe.pick1Vld = 1'b1;
        strobe.pick1    = RS_IDX_W'(e);
        best1           = entAge[e];
      end
    end
    for (int e = 0; e < RS_DEPTH; e++) begin
      if ((strobe.pick0Vld && strobe.pick0 == RS_IDX_W'(e)) ||
          (strobe.pick1Vld && strobe.pick1 == RS_IDX_W'(e)))
        issueMask[e] = 1'b1;
    end
    // lowest free slot takes the dispatch
    for (int e = 0; e < RS_DEPTH; e++) begin
      if (!found && !validQ[e] && dispValid && !dispDropped) begin
        strobe.allocMask[e] = 1'b1;
        found               = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= '0;
    else       validQ <= (validQ & ~issueMask & ~killMask) | strobe.allocMask;
  end
endmodule

// File: rtl/rs_dual_select.sv
module rs_dual_select
  import rs_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 5,
  parameter int AGE_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  output logic              dispReady,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [TAG_W-1:0]  dispDst,
  input  logic [AGE_W-1:0]  dispAge,
  input  logic              dispARdy,
  input  logic [TAG_W-1:0]  dispATag,
  input  logic [DATA_W-1:0] dispAVal,
  input  logic              dispBRdy,
  input  logic [TAG_W-1:0]  dispBTag,
  input  logic [DATA_W-1:0] dispBVal,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastVal,
  input  logic              flushValid,
  input  logic [AGE_W-1:0]  flushAge,
  output logic              iss0Valid,
  output logic [OP_W-1:0]   iss0Op,
  output logic [TAG_W-1:0]  iss0Dst,
  output logic [AGE_W-1:0]  iss0Age,
  output logic [DATA_W-1:0] iss0SrcA,
  output logic [DATA_W-1:0] iss0SrcB,
  output logic              iss1Valid,
  output logic [OP_W-1:0]   iss1Op,
  output logic [TAG_W-1:0]  iss1Dst,
  output logic [AGE_W-1:0]  iss1Age,
  output logic [DATA_W-1:0] iss1SrcA,
  output logic [DATA_W-1:0] iss1SrcB
);
  rsStrobe_t           strobe;
  logic [RS_DEPTH-1:0] entReady;
  logic [RS_DEPTH-1:0] entValid;
  logic [AGE_W-1:0]    entAge [RS_DEPTH];

  rs_ctrl #(.AGE_W(AGE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispAge(dispAge),
    .flushValid(flushValid), .flushAge(flushAge), .entReady(entReady),
    .entAge(entAge), .dispReady(dispReady), .strobe(strobe), .entValid(entValid)
  );

  rs_data #(.OP_W(OP_W), .TAG_W(TAG_W), .AGE_W(AGE_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dispOp(dispOp), .dispDst(dispDst), .dispAge(dispAge),
    .dispARdy(dispARdy), .dispATag(dispATag), .dispAVal(dispAVal),
    .dispBRdy(dispBRdy), .dispBTag(dispBTag), .dispBVal(dispBVal),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastVal(bcastVal),
    .entReady(entReady), .entAge(entAge),
    .iss0Op(iss0Op), .iss0Dst(iss0Dst), .iss0Age(iss0Age),
    .iss0SrcA(iss0SrcA), .iss0SrcB(iss0SrcB),
    .iss1Op(iss1Op), .iss1Dst(iss1Dst), .iss1Age(iss1Age),
    .iss1SrcA(iss1SrcA), .iss1SrcB(iss1SrcB)
  );

  assign iss0Valid = strobe.pick0Vld;
  assign iss1Valid = strobe.pick1Vld;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int AGE_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispReady,
  input logic             flushValid,
  input logic [AGE_W-1:0] flushAge,
  input logic             iss0Valid,
  input logic [AGE_W-1:0] iss0Age,
  input logic             iss1Valid,
  input logic [AGE_W-1:0] iss1Age
);
  assert_port_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    iss1Valid |-> iss0Valid);

  assert_oldest_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (iss0Valid && iss1Valid) |-> (iss0Age < iss1Age));

  assert_flush_mask0_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && iss0Valid) |-> (iss0Age <= flushAge));

  assert_flush_mask1_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && iss1Valid) |-> (iss1Age <= flushAge));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!dispReady && !iss0Valid && !flushValid) |=> !dispReady);

  assert_free_next_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!dispReady && iss0Valid) |=> dispReady);
endmodule

bind rs_dual_select rs_checker #(.AGE_W(AGE_W)) i_rs_checker (
  .clk(clk), .rstN(rstN), .dispReady(dispReady),
  .flushValid(flushValid), .flushAge(flushAge),
  .iss0Valid(iss0Valid), .iss0Age(iss0Age),
  .iss1Valid(iss1Valid), .iss1Age(iss1Age)
);

// File: tb/test_rs_dual_select.sv
`timescale 1ns/1ps
module test_rs_dual_select;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dValid = 1'b0, dARdy = 1'b0, dBRdy = 1'b0;
  logic [3:0]  dOp = '0;
  logic [4:0]  dDst = '0, dATag = '0, dBTag = '0;
  logic [7:0]  dAge = '0;
  logic [15:0] dAVal = '0, dBVal = '0;
  logic        bValid = 1'b0;
  logic [4:0]  bTag = '0;
  logic [15:0] bVal = '0;
  logic        fValid = 1'b0;
  logic [7:0]  fAge = '0;

  logic        dispReady, iss0Valid, iss1Valid;
  logic [3:0]  iss0Op, iss1Op;
  logic [4:0]  iss0Dst, iss1Dst;
  logic [7:0]  iss0Age, iss1Age;
  logic [15:0] iss0SrcA, iss0SrcB, iss1SrcA, iss1SrcB;

  always #5 clk = ~clk;

  rs_dual_select i_rs_dual_select (
    .clk(clk), .rstN(rstN), .dispValid(dValid), .dispReady(dispReady),
    .dispOp(dOp), .dispDst(dDst), .dispAge(dAge),
    .dispARdy(dARdy), .dispATag(dATag), .dispAVal(dAVal),
    .dispBRdy(dBRdy), .dispBTag(dBTag), .dispBVal(dBVal),
    .bcastValid(bValid), .bcastTag(bTag), .bcastVal(bVal),
    .flushValid(fValid), .flushAge(fAge),
    .iss0Valid(iss0Valid), .iss0Op(iss0Op), .iss0Dst(iss0Dst), .iss0Age(iss0Age),
    .iss0SrcA(iss0SrcA), .iss0SrcB(iss0SrcB),
    .iss1Valid(iss1Valid), .iss1Op(iss1Op), .iss1Dst(iss1Dst), .iss1Age(iss1Age),
    .iss1SrcA(iss1SrcA), .iss1SrcB(iss1SrcB)
  );

  // reference model of the queue
  bit          mV [N];
  logic [3:0]  mOp [N];
  logic [4:0]  mDst [N], mATag [N], mBTag [N];
  logic [7:0]  mAge [N];
  bit          mARdy [N], mBRdy [N];
  logic [15:0] mAVal [N], mBVal [N];

  int total = 0;
  int failed = 0;

  task automatic chk(input string lbl, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", lbl, what, got, exp);
    end
  endtask

  task automatic idle();
    dValid = 1'b0; bValid = 1'b0; fValid = 1'b0;
  endtask

  task automatic disp(input logic [7:0] age, input logic [3:0] op, input logic [4:0] dst,
                      input bit ar, input logic [4:0] at, input logic [15:0] av,
                      input bit br, input logic [4:0] bt, input logic [15:0] bv);
    dValid = 1'b1; dAge = age; dOp = op; dDst = dst;
    dARdy = ar; dATag = at; dAVal = av; dBRdy = br; dBTag = bt; dBVal = bv;
  endtask

  // one cycle: compare outputs with the model, then advance the model past the edge
  task automatic step(input string lbl);
    bit kill [N];
    bit elig [N];
    bit anyFree, p0v, p1v, acc;
    int p0, p1, slot;
    #1;
    anyFree = 1'b0; slot = -1; p0v = 1'b0; p1v = 1'b0; p0 = 0; p1 = 0;
    for (int e = 0; e < N; e++) begin
      kill[e] = fValid && mV[e] && (mAge[e] > fAge);
      elig[e] = mV[e] && mARdy[e] && mBRdy[e] && !kill[e];
      if (!mV[e]) begin
        anyFree = 1'b1;
        if (slot < 0) slot = e;
      end
    end
    for (int e = 0; e < N; e++)
      if (elig[e] && (!p0v || mAge[e] < mAge[p0])) begin p0v = 1'b1; p0 = e; end
    for (int e = 0; e < N; e++)
      if (elig[e] && e != p0 && (!p1v || mAge[e] < mAge[p1])) begin p1v = 1'b1; p1 = e; end
    chk(lbl, "dispReady", 32'(dispReady), 32'(anyFree));
    chk(lbl, "iss0Valid", 32'(iss0Valid), 32'(p0v));
    chk(lbl, "iss1Valid", 32'(iss1Valid), 32'(p1v));
    if (p0v) begin
      chk(lbl, "iss0Age", 32'(iss0Age), 32'(mAge[p0]));
      chk(lbl, "iss0Op", 32'(iss0Op), 32'(mOp[p0]));
      chk(lbl, "iss0Dst", 32'(iss0Dst), 32'(mDst[p0]));
      chk(lbl, "iss0SrcA", 32'(iss0SrcA), 32'(mAVal[p0]));
      chk(lbl, "iss0SrcB", 32'(iss0SrcB), 32'(mBVal[p0]));
    end
    if (p1v) begin
      chk(lbl, "iss1Age", 32'(iss1Age), 32'(mAge[p1]));
      chk(lbl, "iss1Op", 32'(iss1Op), 32'(mOp[p1]));
      chk(lbl, "iss1Dst", 32'(iss1Dst), 32'(mDst[p1]));
      chk(lbl, "iss1SrcA", 32'(iss1SrcA), 32'(mAVal[p1]));
      chk(lbl, "iss1SrcB", 32'(iss1SrcB), 32'(mBVal[p1]));
    end
    acc = dValid && anyFree && !(fValid && dAge > fAge);
    @(posedge clk);
    for (int e = 0; e < N; e++) begin
      if (mV[e]) begin
        if (kill[e] || (p0v && p0 == e) || (p1v && p1 == e)) mV[e] = 1'b0;
        else begin
          if (bValid && !mARdy[e] && mATag[e] == bTag) begin mARdy[e] = 1'b1; mAVal[e] = bVal; end
          if (bValid && !mBRdy[e] && mBTag[e] == bTag) begin mBRdy[e] = 1'b1; mBVal[e] = bVal; end
        end
      end
    end
    if (acc) begin
      mV[slot] = 1'b1; mOp[slot] = dOp; mDst[slot] = dDst; mAge[slot] = dAge;
      mATag[slot] = dATag; mBTag[slot] = dBTag;
      mARdy[slot] = dARdy || (bValid && dATag == bTag);
      mBRdy[slot] = dBRdy || (bValid && dBTag == bTag);
      mAVal[slot] = dARdy ? dAVal : bVal;
      mBVal[slot] = dBRdy ? dBVal : bVal;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int ageCtr;
    bit took;
    for (int e = 0; e < N; e++) mV[e] = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    idle(); step("R1");

    // R2: ready-at-dispatch entry issues next cycle, then leaves (R9)
    disp(8'd1, 4'h1, 5'd1, 1, 5'd0, 16'h0011, 1, 5'd0, 16'h0022); step("R2");
    idle(); step("R2");
    step("R9");

    // R6: older waits on tag 7, younger ready overtakes; R3 wakeup
    disp(8'd2, 4'h2, 5'd2, 0, 5'd7, 16'h0, 1, 5'd0, 16'h0033); step("R6");
    disp(8'd3, 4'h3, 5'd3, 1, 5'd0, 16'h0044, 1, 5'd0, 16'h0055); step("R6");
    idle(); bValid = 1'b1; bTag = 5'd7; bVal = 16'h0abc; step("R6");
    idle(); step("R3");
    step("R9");

    // R4: broadcast in the dispatch cycle is captured
    disp(8'd4, 4'h4, 5'd4, 1, 5'd0, 16'h0066, 0, 5'd9, 16'h0);
    bValid = 1'b1; bTag = 5'd9; bVal = 16'h1234; step("R4");
    idle(); step("R4");

    // R7: fill all slots with waiters on tag 20
    for (int k = 0; k < N; k++) begin
      disp(8'(5 + k), 4'(k), 5'(10 + k), 0, 5'd20, 16'h0, 1, 5'd0, 16'(k));
      step("R7");
    end
    disp(8'd11, 4'hf, 5'd31, 1, 5'd0, 16'h0, 1, 5'd0, 16'h0); step("R7"); // dropped
    idle(); bValid = 1'b1; bTag = 5'd20; bVal = 16'h7777; step("R7");
    idle(); step("R5");
    step("R7");
    step("R5");

    // R8: flush younger than 12 while dispatching age 15
    disp(8'd12, 4'h1, 5'd1, 0, 5'd21, 16'h0, 1, 5'd0, 16'h1);  step("R8");
    disp(8'd13, 4'h2, 5'd2, 0, 5'd21, 16'h0, 1, 5'd0, 16'h2);  step("R8");
    disp(8'd14, 4'h3, 5'd3, 1, 5'd0, 16'h3, 1, 5'd0, 16'h3);   step("R8");
    disp(8'd15, 4'h4, 5'd4, 1, 5'd0, 16'h4, 1, 5'd0, 16'h4);
    fValid = 1'b1; fAge = 8'd12; step("R8");
    idle(); bValid = 1'b1; bTag = 5'd21; bVal = 16'h00ee; step("R8");
    idle(); step("R8");
    step("R8");

    // constrained random phases
    for (int ph = 0; ph < 4; ph++) begin
      ageCtr = 1;
      for (int c = 0; c < 150; c++) begin
        idle();
        dValid = ($urandom % 3) != 0;
        dAge = 8'(ageCtr); dOp = 4'($urandom); dDst = 5'($urandom);
        dARdy = $urandom % 2; dATag = 5'($urandom % 8); dAVal = 16'($urandom);
        dBRdy = $urandom % 2; dBTag = 5'($urandom % 8); dBVal = 16'($urandom);
        bValid = ($urandom % 3) != 0; bTag = 5'($urandom % 8); bVal = 16'($urandom);
        if (($urandom % 30) == 0 && ageCtr > 4) begin
          fValid = 1'b1; fAge = 8'(ageCtr - 1 - int'($urandom % 4));
        end
        took = dValid && dispReady;
        step("R5");
        if (took) ageCtr++;
      end
      idle(); fValid = 1'b1; fAge = 8'd0; step("R8");
      idle(); step("R8");
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule